// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block sits between a host bus and the write sequencer of an embedded flash controller. Every host write cycle carries a command byte on the low data lanes. The decoder turns these bytes into actions. It keeps track of which read plane the host currently sees: array data, the status register, or the identifier. It accepts two-write sequences that start a program or a block erase, and on the second write it captures the target address and data. It sends start, suspend and resume pulses to the sequencer and a clear pulse to the status register.

The sequencer reports its state on three level inputs: program running, erase running, and erase suspended. The decoder uses these levels to screen commands. While a program runs, it honours only a status read. While an erase runs, it honours only a status read and a suspend. While an erase is suspended, it honours only array read, resume and status read. After any operation the read plane stays on status until the host asks for the array again.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, readPlane is 0 (array) and every pulse output is low.
- R2: With the sequencer idle and no sequence pending, the command bytes are handled as follows. 0xFF sets readPlane to 0 (array). 0x70 sets it to 1 (status). 0x90 sets it to 2 (identifier).
- R3: With the sequencer idle, 0x50 raises clrStatusPulse for one cycle and leaves readPlane unchanged.
- R4: With the sequencer idle, 0x40 sets readPlane to 1. The next write of any value raises startPulse with startErase=0, and carries that write's full address on startAddr and its data on startData.
- R5: With the sequencer idle, 0x20 sets readPlane to 1. A following 0xD0 raises startPulse with startErase=1, and startBlock holds address bits 16 down to 12 of the confirm write.
- R6: After 0x20, any next byte other than 0xD0 raises failPulse, gives no startPulse, and sets readPlane to 1.
- R7: While seqPrgBusy is high, only 0x70 has an effect. It sets readPlane to 1. Every other write gives no pulse and leaves readPlane unchanged.
- R8: While seqErsBusy is high, only two commands act. 0xB0 raises suspendPulse and sets readPlane to 1. 0x70 sets readPlane to 1. All other writes are ignored.
- R9: While seqSusp is high, only three commands act. 0xFF sets readPlane to 0. 0xD0 raises resumePulse and sets readPlane to 1. 0x70 sets readPlane to 1. All other writes are ignored.
- R10: Every pulse is registered. It is high in the single cycle after the write that causes it, and low in the cycle after that.
- R11: Once an operation ends and the sequencer returns to idle, readPlane stays at 1 until the host writes 0xFF.
- R12: With the sequencer idle and no sequence pending, any other byte, including 0xD0 and 0xB0, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWr | input | 1 | One-cycle host write strobe |
| busAddr | input | ADDR_W | Host write address |
| busData | input | DATA_W | Host write data; the command byte is in bits 7:0 |
| seqPrgBusy | input | 1 | Sequencer is running a program |
| seqErsBusy | input | 1 | Sequencer is running an erase |
| seqSusp | input | 1 | Erase is suspended |
| readPlane | output | 2 | 0 array, 1 status, 2 identifier |
| startPulse | output | 1 | One-cycle start request to the sequencer |
| startErase | output | 1 | Operation type of the start: 1 erase, 0 program |
| startAddr | output | ADDR_W | Address captured at the second write |
| startData | output | DATA_W | Data captured at the second write |
| startBlock | output | BLK_HI-BLK_LO+1 | Block index captured at the second write |
| suspendPulse | output | 1 | One-cycle erase suspend request |
| resumePulse | output | 1 | One-cycle erase resume request |
| clrStatusPulse | output | 1 | One-cycle clear request to the status register |
| failPulse | output | 1 | One-cycle request to set both failure status bits |

## Verification
Directed sequences check the reset state, a program with an unusual data word, and an erase whose confirm address has distinct block bits. They also cover an aborted erase setup and a suspend/resume round trip. Each of these separates the two-write sequence paths from the single-write commands. Seeded random writes then mix the real command codes with arbitrary bytes under each of the four sequencer states. This shows whether the screening matches the state. It catches commands that leak through while the sequencer is busy, and legal ones that are wrongly dropped. Every pulse is also checked to be low one cycle later.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int CMD_W = 8;

  localparam logic [CMD_W-1:0] CMD_RD_ARRAY  = 8'hFF;
  localparam logic [CMD_W-1:0] CMD_RD_STATUS = 8'h70;
  localparam logic [CMD_W-1:0] CMD_CLR_STAT  = 8'h50;
  localparam logic [CMD_W-1:0] CMD_RD_IDENT  = 8'h90;
  localparam logic [CMD_W-1:0] CMD_PGM_SETUP = 8'h40;
  localparam logic [CMD_W-1:0] CMD_ERS_SETUP = 8'h20;
  localparam logic [CMD_W-1:0] CMD_CONFIRM   = 8'hD0;
  localparam logic [CMD_W-1:0] CMD_SUSPEND   = 8'hB0;

  typedef enum logic [1:0] {
    PLANE_ARRAY  = 2'd0,
    PLANE_STATUS = 2'd1,
    PLANE_IDENT  = 2'd2
  } plane_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PGM  = 2'd1,
    PH_ERS  = 2'd2
  } phase_e;

  typedef struct packed {
    logic capture;
    logic isErase;
  } ctrlStrobes_t;
endpackage

// File: rtl/fcd_ctrl.sv
module fcd_ctrl
  import fcd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWr,
  input  logic [CMD_W-1:0] cmd,
  input  logic             seqPrgBusy,
  input  logic             seqErsBusy,
  input  logic             seqSusp,
  output plane_e           readPlane,
  output logic             suspendPulse,
  output logic             resumePulse,
  output logic             clrStatusPulse,
  output logic             failPulse,
  output ctrlStrobes_t     strb
);
  phase_e phase, phaseNext;
  plane_e planeNext;
  logic   suspNext, resumeNext, clrNext, failNext;

  always_comb begin
    phaseNext    = phase;
    planeNext    = readPlane;
    suspNext     = 1'b0;
    resumeNext   = 1'b0;
    clrNext      = 1'b0;
    failNext     = 1'b0;
    strb         = '0;
    if (busWr) begin
      if (seqPrgBusy) begin
        if (cmd == CMD_RD_STATUS) planeNext = PLANE_STATUS;
      end else if (seqSusp) begin
        case (cmd)
          CMD_RD_ARRAY:  planeNext = PLANE_ARRAY;
          CMD_RD_STATUS: planeNext = PLANE_STATUS;
          CMD_CONFIRM: begin
            resumeNext = 1'b1;
            planeNext  = PLANE_STATUS;
          end
          default: ;
        endcase
      end else if (seqErsBusy) begin
        case (cmd)
          CMD_RD_STATUS: planeNext = PLANE_STATUS;
          CMD_SUSPEND: begin
            suspNext  = 1'b1;
            planeNext = PLANE_STATUS;
          end
          default: ;
        endcase
      end else begin
        case (phase)
          PH_PGM: begin
            strb.capture = 1'b1;
            phaseNext    = PH_IDLE;
          end
          PH_ERS: begin
            if (cmd == CMD_CONFIRM) begin
              strb.capture = 1'b1;
              strb.isErase = 1'b1;
            end else begin
              failNext = 1'b1;
            end
            planeNext = PLANE_STATUS;
            phaseNext = PH_IDLE;
          end
          default: begin
            case (cmd)
              CMD_RD_ARRAY:  planeNext = PLANE_ARRAY;
              CMD_RD_STATUS: planeNext = PLANE_STATUS;
              CMD_RD_IDENT:  planeNext = PLANE_IDENT;
              CMD_CLR_STAT:  clrNext   = 1'b1;
              CMD_PGM_SETUP: begin
                phaseNext = PH_PGM;
                planeNext = PLANE_STATUS;
              end
              CMD_ERS_SETUP: begin
                phaseNext = PH_ERS;
                planeNext = PLANE_STATUS;
              end
              default: ;
            endcase
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase          <= PH_IDLE;
      readPlane      <= PLANE_ARRAY;
      suspendPulse   <= 1'b0;
      resumePulse    <= 1'b0;
      clrStatusPulse <= 1'b0;
      failPulse      <= 1'b0;
    end else begin
      phase          <= phaseNext;
      readPlane      <= planeNext;
      suspendPulse   <= suspNext;
      resumePulse    <= resumeNext;
      clrStatusPulse <= clrNext;
      failPulse      <= failNext;
    end
  end

  // R10
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({suspendPulse, resumePulse, clrStatusPulse, failPulse}));

  // R7
  prg_screen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && seqPrgBusy) |=> !(suspendPulse || resumePulse || clrStatusPulse || failPulse));

  // R9
  resume_susp_chk: assert property (@(posedge clk) disable iff (!rstN)
    resumePulse |-> $past(seqSusp));

  // R8
  susp_plane_chk: assert property (@(posedge clk) disable iff (!rstN)
    suspendPulse |-> (readPlane == PLANE_STATUS));

  // R6
  fail_plane_chk: assert property (@(posedge clk) disable iff (!rstN)
    failPulse |-> (readPlane == PLANE_STATUS));
endmodule

// File: rtl/fcd_datapath.sv
module fcd_datapath
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16,
  parameter int BLK_HI = 16,
  parameter int BLK_LO = 12,
  localparam int BLK_W = BLK_HI - BLK_LO + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  output logic              startPulse,
  output logic              startErase,
  output logic [ADDR_W-1:0] startAddr,
  output logic [DATA_W-1:0] startData,
  output logic [BLK_W-1:0]  startBlock
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startPulse <= 1'b0;
      startErase <= 1'b0;
      startAddr  <= '0;
      startData  <= '0;
      startBlock <= '0;
    end else begin
      startPulse <= strb.capture;
      if (strb.capture) begin
        startErase <= strb.isErase;
        startAddr  <= busAddr;
        startData  <= busData;
        startBlock <= busAddr[BLK_HI:BLK_LO];
      end
    end
  end

  // R10
  start_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse);

  // R4
  start_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && !strb.capture) |=> $stable(startAddr) && $stable(startData));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16,
  parameter int BLK_HI = 16,
  parameter int BLK_LO = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     busWr,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic [DATA_W-1:0]        busData,
  input  logic                     seqPrgBusy,
  input  logic                     seqErsBusy,
  input  logic                     seqSusp,
  output logic [1:0]               readPlane,
  output logic                     startPulse,
  output logic                     startErase,
  output logic [ADDR_W-1:0]        startAddr,
  output logic [DATA_W-1:0]        startData,
  output logic [BLK_HI-BLK_LO:0]   startBlock,
  output logic                     suspendPulse,
  output logic                     resumePulse,
  output logic                     clrStatusPulse,
  output logic                     failPulse
);
  ctrlStrobes_t strb;
  plane_e       plane;

  assign readPlane = plane;

  fcd_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .busWr          (busWr),
    .cmd            (busData[CMD_W-1:0]),
    .seqPrgBusy     (seqPrgBusy),
    .seqErsBusy     (seqErsBusy),
    .seqSusp        (seqSusp),
    .readPlane      (plane),
    .suspendPulse   (suspendPulse),
    .resumePulse    (resumePulse),
    .clrStatusPulse (clrStatusPulse),
    .failPulse      (failPulse),
    .strb           (strb)
  );

  fcd_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BLK_HI (BLK_HI),
    .BLK_LO (BLK_LO)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .busAddr    (busAddr),
    .busData    (busData),
    .startPulse (startPulse),
    .startErase (startErase),
    .startAddr  (startAddr),
    .startData  (startData),
    .startBlock (startBlock)
  );
endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
  localparam int ADDR_W = 17;
  localparam int DATA_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busData = '0;
  logic seqPrgBusy = 1'b0, seqErsBusy = 1'b0, seqSusp = 1'b0;
  logic [1:0] readPlane;
  logic startPulse, startErase, suspendPulse, resumePulse, clrStatusPulse, failPulse;
  logic [ADDR_W-1:0] startAddr;
  logic [DATA_W-1:0] startData;
  logic [4:0] startBlock;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  logic [1:0] mPlane = 2'd0;
  int         mPhase = 0;  // 0 idle, 1 program pending, 2 erase pending
  logic [5:0] ePulses;     // {start, erase, susp, resume, clr, fail}
  logic [ADDR_W-1:0] eAddr;
  logic [DATA_W-1:0] eData;

  always #2.5 clk = ~clk;

  flash_cmd_decoder u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busData(busData),
    .seqPrgBusy(seqPrgBusy), .seqErsBusy(seqErsBusy), .seqSusp(seqSusp),
    .readPlane(readPlane), .startPulse(startPulse), .startErase(startErase),
    .startAddr(startAddr), .startData(startData), .startBlock(startBlock),
    .suspendPulse(suspendPulse), .resumePulse(resumePulse),
    .clrStatusPulse(clrStatusPulse), .failPulse(failPulse)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model: mode 0 idle, 1 programming, 2 erasing, 3 suspended
  function automatic string model(input int mode, input logic [7:0] c,
                                  input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    ePulses = '0;
    if (mode == 1) begin
      if (c == 8'h70) mPlane = 2'd1;
      return "R7";
    end
    if (mode == 3) begin
      if (c == 8'hFF) mPlane = 2'd0;
      else if (c == 8'h70) mPlane = 2'd1;
      else if (c == 8'hD0) begin mPlane = 2'd1; ePulses[2] = 1'b1; end
      return "R9";
    end
    if (mode == 2) begin
      if (c == 8'h70) mPlane = 2'd1;
      else if (c == 8'hB0) begin mPlane = 2'd1; ePulses[3] = 1'b1; end
      return "R8";
    end
    if (mPhase == 1) begin
      mPhase = 0; ePulses[5] = 1'b1; eAddr = a; eData = d;
      return "R4";
    end
    if (mPhase == 2) begin
      mPhase = 0; mPlane = 2'd1;
      if (c == 8'hD0) begin ePulses[5] = 1'b1; ePulses[4] = 1'b1; eAddr = a; eData = d; return "R5"; end
      ePulses[0] = 1'b1;
      return "R6";
    end
    case (c)
      8'hFF: begin mPlane = 2'd0; return "R2"; end
      8'h70: begin mPlane = 2'd1; return "R2"; end
      8'h90: begin mPlane = 2'd2; return "R2"; end
      8'h50: begin ePulses[1] = 1'b1; return "R3"; end
      8'h40: begin mPhase = 1; mPlane = 2'd1; return "R4"; end
      8'h20: begin mPhase = 2; mPlane = 2'd1; return "R5"; end
      default: return "R12";
    endcase
  endfunction

  task automatic wr(input int mode, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    string req;
    req = model(mode, d[7:0], a, d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busData = d;
    seqPrgBusy = (mode == 1); seqErsBusy = (mode == 2); seqSusp = (mode == 3);
    @(negedge clk);
    busWr = 1'b0;
    chk(req, {62'd0, readPlane}, {62'd0, mPlane});
    chk(req, {58'd0, startPulse, suspendPulse, resumePulse, clrStatusPulse, failPulse},
             {58'd0, ePulses[5], ePulses[3], ePulses[2], ePulses[1], ePulses[0]});
    if (ePulses[5]) begin
      chk(req, {63'd0, startErase}, {63'd0, ePulses[4]});
      chk(req, {47'd0, startAddr}, {47'd0, eAddr});
      if (ePulses[4]) chk("R5", {59'd0, startBlock}, {59'd0, eAddr[16:12]});
      else chk("R4", {48'd0, startData}, {48'd0, eData});
    end
    @(negedge clk);
    chk("R10", {59'd0, startPulse, suspendPulse, resumePulse, clrStatusPulse, failPulse}, 64'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] codes [10];
    codes = '{8'hFF, 8'h70, 8'h50, 8'h90, 8'h40, 8'h20, 8'hD0, 8'hB0, 8'h00, 8'h3C};
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {62'd0, readPlane}, 64'd0);
    chk("R1", {59'd0, startPulse, suspendPulse, resumePulse, clrStatusPulse, failPulse}, 64'd0);
    rstN = 1'b1;
    // directed
    wr(0, 17'h0, 16'h0090);
    wr(0, 17'h0, 16'h0050);
    wr(0, 17'h0, 16'h00B0);                  // R12
    wr(0, 17'h0, 16'h00D0);                  // R12
    wr(0, 17'h0, 16'h0040);
    wr(0, 17'h1ABCD, 16'hA5FF);              // R4 data byte looks like read-array
    wr(1, 17'h0, 16'h00FF);                  // R7 ignored
    wr(1, 17'h0, 16'h0050);                  // R7 ignored
    wr(0, 17'h0, 16'h0000);                  // R11 plane stays status
    chk("R11", {62'd0, readPlane}, 64'd1);
    wr(0, 17'h0, 16'h00FF);
    wr(0, 17'h0, 16'h0020);
    wr(0, 17'h15432, 16'h00D0);              // R5 block 0x15
    wr(2, 17'h0, 16'h00FF);                  // R8 ignored
    wr(2, 17'h0, 16'h00B0);                  // R8 suspend
    wr(3, 17'h0, 16'h00FF);                  // R9 array
    wr(3, 17'h0, 16'h0040);                  // R9 ignored
    wr(3, 17'h0, 16'h00D0);                  // R9 resume
    wr(0, 17'h0, 16'h0020);
    wr(0, 17'h0, 16'h0070);                  // R6 abort
    // random
    for (int i = 0; i < 600; i++) begin
      int mode;
      logic [DATA_W-1:0] d;
      mode = (mPhase != 0) ? 0 : int'($urandom_range(0, 3));
      d = DATA_W'($urandom);
      if ($urandom_range(0, 3) != 0) d[7:0] = codes[$urandom_range(0, 9)];
      wr(mode, ADDR_W'($urandom), d);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule